// File: doc/BRIEF.md
# Bus-Master DMA Channel Register and Sequencing Block

This block is the control side of one bus-master DMA channel. Software programs two registers. The first holds the 32-bit address of a descriptor table, and its two low bits select the direction. The second is a 16-bit count, and writing it starts the transfer; there is no separate go bit. The count is loaded as twice the number of table entries minus one. Each entry is two 32-bit words: a data address and a byte length. The block fetches the entry words in order through a simple request/acknowledge memory port. For each entry it moves 32-bit data words between memory and a drive-side data port.

When the last entry has been served, the status word reads exactly 0x00FF and the channel's bus-master interrupt status bit is set. An external mask input can hide the interrupt output. A second copy of the block, parameterised as channel 1, answers at the same register offsets XORed with 0x80.

The sequencer has eight named states:
- ST_IDLE: waits for a start.
- ST_DESC_ADDR: fetches an entry's address word.
- ST_DESC_LEN: fetches an entry's length word.
- ST_MEM_RD: reads a data word from memory.
- ST_DRV_PUSH: offers that word to the drive.
- ST_DRV_POP: takes a word from the drive.
- ST_MEM_WR: writes that word to memory.
- ST_FINISH: a one-cycle completion state.

Its transitions are:
- start: ST_IDLE to ST_DESC_ADDR.
- address fetched: ST_DESC_ADDR to ST_DESC_LEN.
- length fetched: ST_DESC_LEN to ST_MEM_RD when the direction is memory-to-drive, to ST_DRV_POP when it is drive-to-memory, or, for an empty entry, to ST_DESC_ADDR or ST_FINISH.
- word read: ST_MEM_RD to ST_DRV_PUSH.
- word popped: ST_DRV_POP to ST_MEM_WR.
- word done: from ST_DRV_PUSH or ST_MEM_WR back to the data state of the same entry, to ST_DESC_ADDR for the next entry, or to ST_FINISH after the last word.
- finish: ST_FINISH to ST_IDLE.

Top module: `bmdma_channel`

## Requirements
- R1: After reset the status word at offset 0x02 reads 0x0000, both interrupt outputs are low, and mem_req, drv_wr_valid and drv_rd_ready are low.
- R2: A write to offset 0x00 loads the 32-bit table pointer, which reads back at offset 0x00. Pointer bits [1:0] give the direction: 2'b01 moves memory to drive, and 2'b10 moves drive to memory.
- R3: A write to offset 0x02 loads the count from reg_wdata[15:0] and starts a transfer when the channel is idle and the direction is 2'b01 or 2'b10. With direction 2'b00 or 2'b11 the write starts nothing.
- R4: Entry i is read at the table base (pointer with bits [1:0] cleared) plus 8*i: first the address word, whose bits [1:0] are ignored, then the byte-length word. The count falls by one per entry word fetched. A count of 2N-1 serves N entries, in order.
- R5: In memory-to-drive mode, each entry moves length/4 words. Word k is read from address + 4k and presented on drv_wdata until drv_wr_ready accepts it, in order.
- R6: In drive-to-memory mode, each word taken from the drive port (drv_rd_valid and drv_rd_ready) is written to address + 4k, in order.
- R7: An entry whose byte length is below 4 moves no data, and the next entry follows.
- R8: While a transfer is active, offset 0x02 reads 0x8000 OR the low 15 bits of the remaining count, and never reads 0x00FF. After completion it reads exactly 0x00FF until the next start.
- R9: Completion sets bm_irq_status. The irq output equals bm_irq_status AND NOT irq_mask.
- R10: Reading the status does not clear bm_irq_status. A pointer write while idle clears it.
- R11: Pointer and count writes made while a transfer is active are ignored.
- R12: The registers answer at offsets 0x00 and 0x02 XORed with 0x80 when CHAN_ID is 1, and with 0x00 when CHAN_ID is 0. Other offsets ignore writes and read 0.
- R13: A memory request holds its address, direction and write data until mem_ack. At most one of mem_req, drv_wr_valid and drv_rd_ready is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_mask | input | 1 | Masks the interrupt output when high |
| bm_irq_status | output | 1 | Raw bus-master completion status |
| irq | output | 1 | Masked interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| drv_wr_valid | output | 1 | Word offered to the drive |
| drv_wr_ready | input | 1 | Drive accepts the offered word |
| drv_wdata | output | 32 | Word to the drive |
| drv_rd_valid | input | 1 | Drive has a word available |
| drv_rd_ready | output | 1 | Block takes the drive word |
| drv_rdata | input | 32 | Word from the drive |

## Verification
The in-design assertions check, on every cycle, the properties that span registers and the sequencer:
- the pointer stays stable while the channel is busy;
- the status never reads the completion code while busy;
- the interrupt rises after the finish state and persists until a pointer write;
- memory requests and drive offers hold until acknowledged;
- at most one port is active at a time.

Only the bench scenarios can show what depends on table contents and timing:
- the exact order and addresses of entry and data accesses under random stalls;
- skipping of empty entries;
- the data words delivered in both directions;
- rejection of bad direction codes and of writes made mid-transfer;
- the decode of the 0x80 alias.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    localparam logic [7:0]  OFS_TABLE   = 8'h00;
    localparam logic [7:0]  OFS_COUNT   = 8'h02;
    localparam logic [7:0]  CHAN_XOR    = 8'h80;
    localparam logic [15:0] DONE_CODE   = 16'h00FF;
    localparam logic [15:0] ACTIVE_FLAG = 16'h8000;

    typedef enum logic [1:0] {
        DIR_NONE       = 2'b00,
        DIR_TO_DRIVE   = 2'b01,
        DIR_FROM_DRIVE = 2'b10,
        DIR_BAD        = 2'b11
    } xfer_dir_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_ADDR,
        ST_DESC_LEN,
        ST_MEM_RD,
        ST_DRV_PUSH,
        ST_DRV_POP,
        ST_MEM_WR,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int REG_AW  = 8,
    parameter int CHAN_ID = 0
) (
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    output logic              hit_table,
    output logic              hit_count,
    output logic              tbl_wr,
    output logic              cnt_wr
);
    localparam logic [REG_AW-1:0] TBL_OFS = REG_AW'(OFS_TABLE);
    localparam logic [REG_AW-1:0] CNT_OFS = REG_AW'(OFS_COUNT);

    logic [REG_AW-1:0] local_ofs;

    generate
        if (CHAN_ID != 0) begin : g_chan1
            assign local_ofs = reg_addr ^ REG_AW'(CHAN_XOR);
        end else begin : g_chan0
            assign local_ofs = reg_addr;
        end
    endgenerate

    always_comb begin
        hit_table = (local_ofs == TBL_OFS);
        hit_count = (local_ofs == CNT_OFS);
        tbl_wr    = reg_wr && hit_table;
        cnt_wr    = reg_wr && hit_count;
    end

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_i,
    input  logic              cnt_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              desc_step_i,
    input  logic              finish_i,
    output logic [DATA_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output xfer_dir_t         dir_o,
    output logic              start_o,
    output logic [15:0]       status_o,
    output logic              irq_stat_o
);
    logic [DATA_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              irq_q;
    logic              dir_ok;

    always_comb begin
        dir_o   = xfer_dir_t'(ptr_q[1:0]);
        dir_ok  = (dir_o == DIR_TO_DRIVE) || (dir_o == DIR_FROM_DRIVE);
        start_o = cnt_wr_i && !busy_i && dir_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (tbl_wr_i && !busy_i) begin
                ptr_q <= wdata_i;
                irq_q <= 1'b0;
            end
            if (start_o) begin
                cnt_q  <= wdata_i[CNT_W-1:0];
                done_q <= 1'b0;
            end else if (desc_step_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (finish_i) begin
                done_q <= 1'b1;
                irq_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        if (busy_i)
            status_o = ACTIVE_FLAG | {1'b0, cnt_q[14:0]};
        else if (done_q)
            status_o = DONE_CODE;
        else
            status_o = 16'h0000;
    end

    assign ptr_o      = ptr_q;
    assign cnt_o      = cnt_q;
    assign irq_stat_o = irq_q;

    // R11
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(ptr_q));

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> irq_q);

    // R8
    busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (status_o != DONE_CODE));

    // R10
    irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !tbl_wr_i) |=> irq_q);

endmodule

// File: rtl/bmdma_seq.sv
module bmdma_seq
    import bmdma_pkg::*;
#(
    parameter int XFER_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  xfer_dir_t         dir_i,
    input  logic [DATA_W-1:0] ptr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              busy_o,
    output logic              desc_step_o,
    output logic              finish_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              drv_wr_valid_o,
    input  logic              drv_wr_ready_i,
    output logic [DATA_W-1:0] drv_wdata_o,
    input  logic              drv_rd_valid_i,
    output logic              drv_rd_ready_o,
    input  logic [DATA_W-1:0] drv_rdata_i
);
    localparam logic [XFER_W-1:0] ONE_WORD = XFER_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    seq_state_t        state_q, state_d;
    xfer_dir_t         dir_q;
    logic [DATA_W-1:0] tbl_q;
    logic [DATA_W-1:0] dat_q;
    logic [DATA_W-1:0] hold_q;
    logic [XFER_W-1:0] words_q;
    logic              last_q;

    logic [XFER_W-1:0] len_words;
    logic              last_now;
    logic              word_done;
    logic              entry_end;

    always_comb begin
        len_words = mem_rdata_i[XFER_W+1:2];
        last_now  = (cnt_i <= CNT_ONE) || (cnt_i == '1);
        word_done = ((state_q == ST_DRV_PUSH) && drv_wr_ready_i) ||
                    ((state_q == ST_MEM_WR) && mem_ack_i);
        entry_end = (words_q == ONE_WORD);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_DESC_ADDR;
            end
            ST_DESC_ADDR: begin
                if (mem_ack_i) state_d = ST_DESC_LEN;
            end
            ST_DESC_LEN: begin
                if (mem_ack_i) begin
                    if (len_words == '0)
                        state_d = last_now ? ST_FINISH : ST_DESC_ADDR;
                    else if (dir_q == DIR_TO_DRIVE)
                        state_d = ST_MEM_RD;
                    else
                        state_d = ST_DRV_POP;
                end
            end
            ST_MEM_RD: begin
                if (mem_ack_i) state_d = ST_DRV_PUSH;
            end
            ST_DRV_POP: begin
                if (drv_rd_valid_i) state_d = ST_MEM_WR;
            end
            ST_DRV_PUSH, ST_MEM_WR: begin
                if (word_done) begin
                    if (!entry_end)
                        state_d = (dir_q == DIR_TO_DRIVE) ? ST_MEM_RD : ST_DRV_POP;
                    else
                        state_d = last_q ? ST_FINISH : ST_DESC_ADDR;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= DIR_NONE;
            tbl_q   <= '0;
            dat_q   <= '0;
            hold_q  <= '0;
            words_q <= '0;
            last_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                dir_q  <= dir_i;
                tbl_q  <= {ptr_i[DATA_W-1:2], 2'b00};
                last_q <= 1'b0;
            end
            if (state_q == ST_DESC_ADDR && mem_ack_i) begin
                dat_q <= {mem_rdata_i[DATA_W-1:2], 2'b00};
                tbl_q <= tbl_q + 32'd4;
            end
            if (state_q == ST_DESC_LEN && mem_ack_i) begin
                words_q <= len_words;
                last_q  <= last_now;
                tbl_q   <= tbl_q + 32'd4;
            end
            if (state_q == ST_MEM_RD && mem_ack_i)
                hold_q <= mem_rdata_i;
            if (state_q == ST_DRV_POP && drv_rd_valid_i)
                hold_q <= drv_rdata_i;
            if (word_done) begin
                dat_q   <= dat_q + 32'd4;
                words_q <= words_q - ONE_WORD;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o         = (state_q != ST_IDLE);
        finish_o       = (state_q == ST_FINISH);
        desc_step_o    = ((state_q == ST_DESC_ADDR) || (state_q == ST_DESC_LEN)) && mem_ack_i;
        mem_req_o      = (state_q == ST_DESC_ADDR) || (state_q == ST_DESC_LEN) ||
                         (state_q == ST_MEM_RD)    || (state_q == ST_MEM_WR);
        mem_we_o       = (state_q == ST_MEM_WR);
        mem_addr_o     = ((state_q == ST_DESC_ADDR) || (state_q == ST_DESC_LEN)) ? tbl_q : dat_q;
        mem_wdata_o    = hold_q;
        drv_wr_valid_o = (state_q == ST_DRV_PUSH);
        drv_wdata_o    = hold_q;
        drv_rd_ready_o = (state_q == ST_DRV_POP);
    end

    // R13
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, drv_wr_valid_o, drv_rd_ready_o}));

    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R5
    push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_wr_valid_o && !drv_wr_ready_i) |=> (drv_wr_valid_o && $stable(drv_wdata_o)));

endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
    import bmdma_pkg::*;
#(
    parameter int REG_AW  = 8,
    parameter int CHAN_ID = 0,
    parameter int XFER_W  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              irq_mask,
    output logic              bm_irq_status,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              drv_wr_valid,
    input  logic              drv_wr_ready,
    output logic [31:0]       drv_wdata,
    input  logic              drv_rd_valid,
    output logic              drv_rd_ready,
    input  logic [31:0]       drv_rdata
);
    logic              hit_table, hit_count, tbl_wr, cnt_wr;
    logic [DATA_W-1:0] ptr;
    logic [CNT_W-1:0]  cnt;
    xfer_dir_t         dir;
    logic              start, busy, desc_step, finish;
    logic [15:0]       status;

    bmdma_decode #(.REG_AW(REG_AW), .CHAN_ID(CHAN_ID)) u_decode (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .hit_table (hit_table),
        .hit_count (hit_count),
        .tbl_wr    (tbl_wr),
        .cnt_wr    (cnt_wr)
    );

    bmdma_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_wr_i    (tbl_wr),
        .cnt_wr_i    (cnt_wr),
        .wdata_i     (reg_wdata),
        .busy_i      (busy),
        .desc_step_i (desc_step),
        .finish_i    (finish),
        .ptr_o       (ptr),
        .cnt_o       (cnt),
        .dir_o       (dir),
        .start_o     (start),
        .status_o    (status),
        .irq_stat_o  (bm_irq_status)
    );

    bmdma_seq #(.XFER_W(XFER_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .dir_i          (dir),
        .ptr_i          (ptr),
        .cnt_i          (cnt),
        .busy_o         (busy),
        .desc_step_o    (desc_step),
        .finish_o       (finish),
        .mem_req_o      (mem_req),
        .mem_we_o       (mem_we),
        .mem_addr_o     (mem_addr),
        .mem_wdata_o    (mem_wdata),
        .mem_rdata_i    (mem_rdata),
        .mem_ack_i      (mem_ack),
        .drv_wr_valid_o (drv_wr_valid),
        .drv_wr_ready_i (drv_wr_ready),
        .drv_wdata_o    (drv_wdata),
        .drv_rd_valid_i (drv_rd_valid),
        .drv_rd_ready_o (drv_rd_ready),
        .drv_rdata_i    (drv_rdata)
    );

    always_comb begin
        if (hit_table)      reg_rdata = ptr;
        else if (hit_count) reg_rdata = {16'h0000, status};
        else                reg_rdata = 32'h0;
        irq = bm_irq_status && !irq_mask;
    end

endmodule

// File: tb/bmdma_channel_tb.sv
`timescale 1ns/1ps
module bmdma_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h02;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_mask = 1'b0;
    logic        bm_irq_status, irq;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        drv_wr_valid, drv_wr_ready, drv_rd_valid, drv_rd_ready;
    logic [31:0] drv_wdata, drv_rdata;

    logic [31:0] mem [0:255];
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] src = 32'hA500_0000;

    int nchecks = 0;
    int nerr = 0;

    int          q_kind[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    bit          active_m = 0;
    bit          done_m = 0;
    bit          exp_irq = 0;
    int          fin_wait = 0;
    logic [31:0] pred_src = 32'hA500_0000;

    always #10 clk = ~clk;

    bmdma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_mask(irq_mask),
        .bm_irq_status(bm_irq_status), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .drv_wr_valid(drv_wr_valid), .drv_wr_ready(drv_wr_ready), .drv_wdata(drv_wdata),
        .drv_rd_valid(drv_rd_valid), .drv_rd_ready(drv_rd_ready), .drv_rdata(drv_rdata)
    );

    assign mem_ack      = mem_req && (lfsr[0] || lfsr[7]);
    assign mem_rdata    = mem[mem_addr[9:2]];
    assign drv_wr_ready = lfsr[3] || lfsr[9];
    assign drv_rd_valid = lfsr[5] || lfsr[11];
    assign drv_rdata    = src;

    always @(negedge clk)
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
        if (drv_rd_valid && drv_rd_ready) src <= src + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    task automatic expect_txn(input int kind, input logic [31:0] addr, input logic [31:0] data);
        q_kind.push_back(kind);
        q_addr.push_back(addr);
        q_data.push_back(data);
    endtask

    // kinds: 0 memory read, 1 memory write, 2 word to drive, 3 word from drive
    task automatic seen_txn(input int kind, input logic [31:0] addr, input logic [31:0] data);
        int k;
        logic [31:0] a, d;
        if (q_kind.size() == 0) begin
            chk(0, "R11 unexpected transfer", {28'h0, 4'(kind)}, 32'hFFFF_FFFF);
            return;
        end
        k = q_kind.pop_front();
        a = q_addr.pop_front();
        d = q_data.pop_front();
        chk(k == kind, "R4 transaction kind", 32'(kind), 32'(k));
        if (kind == 0) chk(addr == a, "R4 read address", addr, a);
        if (kind == 1) begin
            chk(addr == a, "R6 write address", addr, a);
            chk(data == d, "R6 write data", data, d);
        end
        if (kind == 2) chk(data == d, "R5 drive data", data, d);
        if (kind == 3) chk(data == d, "R6 drive source", data, d);
        if (q_kind.size() == 0 && active_m && fin_wait == 0) fin_wait = 2;
    endtask

    // cycle-by-cycle comparison against the behavioural model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (fin_wait > 0) begin
                fin_wait--;
                if (fin_wait == 0) begin
                    active_m = 0;
                    done_m = 1;
                    exp_irq = 1;
                end
            end
            chk(irq === (exp_irq && !irq_mask), "R9 irq", {31'h0, irq}, {31'h0, exp_irq && !irq_mask});
            chk(bm_irq_status === exp_irq, "R10 irq status", {31'h0, bm_irq_status}, {31'h0, exp_irq});
            if (reg_addr == 8'h02) begin
                if (active_m)
                    chk(reg_rdata[31:15] == 17'h1 && reg_rdata[15:0] != 16'h00FF,
                        "R8 active status", reg_rdata, 32'h8000);
                else
                    chk(reg_rdata == (done_m ? 32'h00FF : 32'h0), "R8 idle status",
                        reg_rdata, done_m ? 32'h00FF : 32'h0);
            end
            chk($onehot0({mem_req, drv_wr_valid, drv_rd_ready}), "R13 one port",
                {29'h0, mem_req, drv_wr_valid, drv_rd_ready}, 32'h1);
            if (mem_req && mem_ack) seen_txn(mem_we ? 1 : 0, mem_addr, mem_wdata);
            if (drv_wr_valid && drv_wr_ready) seen_txn(2, 32'h0, drv_wdata);
            if (drv_rd_valid && drv_rd_ready) seen_txn(3, 32'h0, drv_rdata);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_addr = 8'h02;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2;
        v = reg_rdata;
        reg_addr = 8'h02;
    endtask

    task automatic set_ptr(input logic [31:0] p);
        wr(8'h00, p);
        if (!active_m) exp_irq = 0;
    endtask

    task automatic start_xfer(input logic [31:0] p, input int n);
        int idx;
        logic [31:0] a;
        int w;
        logic [31:0] tbl;
        logic [31:0] v;
        idx = int'(p[9:2]);
        tbl = {p[31:2], 2'b00};
        for (int e = 0; e < n; e++) begin
            expect_txn(0, tbl + 32'(8 * e), 0);
            expect_txn(0, tbl + 32'(8 * e + 4), 0);
            a = mem[idx + 2 * e] & 32'hFFFF_FFFC;
            w = int'(mem[idx + 2 * e + 1] >> 2);
            for (int k = 0; k < w; k++) begin
                if (p[1:0] == 2'b01) begin
                    expect_txn(0, a, 0);
                    expect_txn(2, 0, mem[a[9:2]]);
                end else begin
                    expect_txn(3, 0, pred_src);
                    expect_txn(1, a, pred_src);
                    pred_src = pred_src + 1;
                end
                a = a + 4;
            end
        end
        wr(8'h02, 32'(2 * n - 1));
        active_m = 1;
        done_m = 0;
        #2;
        chk(reg_rdata == (32'h8000 | 32'(2 * n - 1)), "R3 start loads count", reg_rdata,
            32'h8000 | 32'(2 * n - 1));
    endtask

    task automatic wait_done();
        while (active_m) @(negedge clk);
        @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R13 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] first;
        for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h111;
        // table A at 0x100: {0x200,12} {0x241,4}
        mem[64] = 32'h200; mem[65] = 12; mem[66] = 32'h241; mem[67] = 4;
        // table B at 0x180: {0x280,8} {0x2A0,2} {0x2C0,4}
        mem[96] = 32'h280; mem[97] = 8; mem[98] = 32'h2A0; mem[99] = 2;
        mem[100] = 32'h2C0; mem[101] = 4;
        // table C at 0x1C0: {0x300,16}
        mem[112] = 32'h300; mem[113] = 16;

        repeat (4) @(negedge clk);
        #2;
        // R1
        chk(reg_rdata == 32'h0, "R1 status after reset", reg_rdata, 32'h0);
        chk({irq, bm_irq_status} == 2'b00, "R1 irq after reset", {30'h0, irq, bm_irq_status}, 32'h0);
        chk({mem_req, drv_wr_valid, drv_rd_ready} == 3'b000, "R1 ports idle",
            {29'h0, mem_req, drv_wr_valid, drv_rd_ready}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 pointer readback, memory-to-drive transfer (R4, R5)
        set_ptr(32'h101);
        rd(8'h00, v);
        chk(v == 32'h101, "R2 pointer readback", v, 32'h101);
        start_xfer(32'h101, 2);
        wait_done();
        chk(reg_rdata == 32'h00FF, "R8 completion code", reg_rdata, 32'h00FF);
        chk(bm_irq_status == 1'b1, "R9 completion interrupt", {31'h0, bm_irq_status}, 32'h1);

        // R10 reads do not clear; mask hides irq
        for (int i = 0; i < 3; i++) rd(8'h02, v);
        chk(bm_irq_status == 1'b1, "R10 status read keeps irq", {31'h0, bm_irq_status}, 32'h1);
        @(negedge clk); irq_mask = 1'b1;
        #2;
        chk(irq == 1'b0, "R9 mask hides irq", {31'h0, irq}, 32'h0);
        @(negedge clk); irq_mask = 1'b0;

        // R6 / R7 drive-to-memory with an empty entry
        set_ptr(32'h182);
        chk(bm_irq_status == 1'b0, "R10 pointer write clears irq", {31'h0, bm_irq_status}, 32'h0);
        first = pred_src;
        start_xfer(32'h182, 3);
        wait_done();
        chk(mem[160] == first, "R6 first word stored", mem[160], first);
        chk(mem[161] == first + 1, "R6 second word stored", mem[161], first + 1);
        chk(mem[176] == first + 2, "R7 entry after empty one", mem[176], first + 2);
        chk(mem[168] == 32'h1000_0000 + 32'd168 * 32'h111, "R7 empty entry moves nothing",
            mem[168], 32'h1000_0000 + 32'd168 * 32'h111);

        // R3 bad direction codes start nothing
        set_ptr(32'h100);
        wr(8'h02, 32'h3);
        repeat (8) @(negedge clk);
        #2;
        chk(reg_rdata == 32'h00FF, "R3 direction 00 ignored", reg_rdata, 32'h00FF);
        set_ptr(32'h103);
        wr(8'h02, 32'h3);
        repeat (8) @(negedge clk);
        #2;
        chk(reg_rdata == 32'h00FF, "R3 direction 11 ignored", reg_rdata, 32'h00FF);

        // R11 writes while active are ignored
        set_ptr(32'h1C1);
        start_xfer(32'h1C1, 1);
        wr(8'h02, 32'h5);
        wr(8'h00, 32'h181);
        rd(8'h00, v);
        chk(v == 32'h1C1, "R11 pointer write ignored while active", v, 32'h1C1);
        wait_done();
        chk(reg_rdata == 32'h00FF, "R11 transfer unchanged", reg_rdata, 32'h00FF);

        // R12 channel-1 alias offsets ignored by channel 0
        wr(8'h80, 32'h3C1);
        rd(8'h00, v);
        chk(v == 32'h1C1, "R12 alias write ignored", v, 32'h1C1);
        rd(8'h80, v);
        chk(v == 32'h0, "R12 unmapped read", v, 32'h0);
        wr(8'h82, 32'h1);
        repeat (8) @(negedge clk);
        #2;
        chk(reg_rdata == 32'h00FF, "R12 alias count ignored", reg_rdata, 32'h00FF);
        chk(q_kind.size() == 0, "R4 all expected transfers seen", 32'(q_kind.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule